// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits between a simple bus write/read port and a small modelled NOR-style array. Bus writes are fed to a command decoder that recognises multi-cycle unlock sequences: a four-write program, a six-write chip erase, a six-write sector erase that can collect several sectors, a shortcut mode in which each program needs only two writes, and commands that pause and continue a running erase. Each write of a sequence latches address and data; the final write hands a request to an operation engine that times the work in clock cycles and then updates the array.

Programming can only clear bits: the cell becomes the old value ANDed with the written data. Erase runs two timed phases, a preprogram pass that clears every cell of the chosen sectors and an erase pass that sets them all to one, so the erase occupies twice the program time. While an operation runs, reads return a status byte instead of array data, and the `ready` output is low. A paused erase lets the host read the array and program sectors outside the erase set before the erase continues. The synchronous active-low reset doubles as the hardware reset: it abandons any operation and sequence and returns the model to a blank, read-mode array.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: One clock edge with `rst_n` low leaves `ready` = 1, the decoder in read mode and every cell at 8'hFF; a read returns the cell value on `rdata` one cycle after `rd_en`.
- R2: The sequence 8'hAA at address 8'h55, 8'h55 at 8'h2A, 8'hA0 at 8'h55, then the data at the target address programs that cell.
- R3: A program stores old AND data, so bits already 0 stay 0.
- R4: A write whose data or address does not match the next expected step of a sequence drops the sequence back to read mode; the writes that follow start no operation and leave the array unchanged.
- R5: `ready` falls after the clock edge that takes the last write of a program and stays low for exactly OP_CYCLES cycles.
- R6: A read while busy returns a status byte: bit 7 is the inverse of bit 7 of the data being programmed (0 during erase), bit 6 changes on every busy read, bits 5..0 are 0.
- R7: 8'hAA at 8'h55, 8'h55 at 8'h2A, 8'h20 at 8'h55 enters a shortcut mode where 8'hA0 at any address then the data at the target programs a cell; 8'h90 then 8'h00 (any addresses) leaves it, after which two-write programs do nothing.
- R8: Sector erase is 8'hAA@8'h55, 8'h55@8'h2A, 8'h80@8'h55, 8'hAA@8'h55, 8'h55@8'h2A, then 8'h30 at an address in the sector; the sector is the top SECT_W address bits. Further 8'h30 writes add sectors and restart a SEL_WINDOW-cycle window; the erase starts SEL_WINDOW cycles after the last one, lasts 2*OP_CYCLES cycles, sets the chosen sectors to 8'hFF and leaves others intact.
- R9: The same five writes followed by 8'h10 at 8'h55 erase every cell; `ready` is low for 2*OP_CYCLES cycles starting at that write.
- R10: 8'hB0 at any address during a running erase raises `ready` on the next edge and freezes the erase; reads return array data, programs outside the erase set complete and return to the paused state, programs into the erase set are dropped, and 8'h30 at any address continues the erase for the remaining cycles only.
- R11: Writes other than the pause command are ignored while `ready` is low.
- R12: Asserting `rst_n` during an operation ends it at the next edge; the targeted cell is not changed and the next read returns array data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also the hardware reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data or command code |
| rdata | output | 8 | Read data or status byte, registered |
| ready | output | 1 | High when no operation is running (paused erase counts as ready) |

## Verification
A decoder stuck in a wrong sequence state shows up on the very next write that should have started or must not start an operation: `ready` either fails to fall or falls when it should not, one edge after that write, and the target cell reads back wrong once the operation time has passed. A counter or freeze fault in the engine shows as a busy window that is too long or too short by whole cycles, which the bench measures exactly, including the remainder after a pause. A wrong sector mask shows as a cell in the wrong sector reading 8'hFF or keeping its value after the erase.

// File: rtl/nor_cmd_pkg.sv
// Shared command codes and decoder state type for the flash command controller.
// Assumes 8-bit command data; address-side keys are parameters of the top.
package nor_cmd_pkg;

    localparam int DW = 8;

    localparam logic [DW-1:0] K_FIRST   = 8'hAA;
    localparam logic [DW-1:0] K_SECOND  = 8'h55;
    localparam logic [DW-1:0] K_PROGRAM = 8'hA0;
    localparam logic [DW-1:0] K_ERASE   = 8'h80;
    localparam logic [DW-1:0] K_WHOLE   = 8'h10;
    localparam logic [DW-1:0] K_SECTOR  = 8'h30;
    localparam logic [DW-1:0] K_FAST    = 8'h20;
    localparam logic [DW-1:0] K_PAUSE   = 8'hB0;
    localparam logic [DW-1:0] K_LEAVE1  = 8'h90;
    localparam logic [DW-1:0] K_LEAVE2  = 8'h00;

    typedef enum logic [3:0] {
        D_READ,   // plain read mode
        D_U1,     // first unlock write seen
        D_U2,     // second unlock write seen
        D_PRG,    // waiting for program data
        D_E1,     // erase setup seen
        D_E2,     // erase: first unlock again
        D_E3,     // erase: second unlock again
        D_SEL,    // collecting sectors
        D_BYP,    // shortcut program mode idle
        D_BPRG,   // shortcut mode, waiting for data
        D_BEXIT   // shortcut mode, first leave write seen
    } dec_st_t;

endpackage

// File: rtl/nor_cmd_decode.sv
// Command sequence decoder. Walks the unlock sequences on bus writes and
// emits single-cycle requests to the operation engine. Assumes the engine
// ignores requests only through eng_busy; all writes are dropped while busy
// except the pause command.
module nor_cmd_decode
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SECT_W     = 2,
    parameter int SEL_WINDOW = 8,
    parameter logic [ADDR_W-1:0] KEY_A1 = 8'h55,
    parameter logic [ADDR_W-1:0] KEY_A2 = 8'h2A
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DW-1:0]             wdata,
    input  logic                      eng_busy,
    input  logic                      ers_run,
    input  logic                      susp,
    input  logic [(1<<SECT_W)-1:0]    ers_mask,
    output logic                      go_prog,
    output logic                      go_erase,
    output logic [(1<<SECT_W)-1:0]    erase_sel,
    output logic                      suspend_req,
    output logic                      resume_req
);

    localparam int NSECT = 1 << SECT_W;
    localparam int TW    = $clog2(SEL_WINDOW + 1);

    dec_st_t           st, st_nxt;
    logic [NSECT-1:0]  sel, sel_nxt;
    logic [TW-1:0]     tmr, tmr_nxt;
    logic              wr_ok, at_a1, at_a2;
    logic [NSECT-1:0]  sect_oh;

    assign wr_ok   = wr_en && !eng_busy;
    assign at_a1   = (addr == KEY_A1);
    assign at_a2   = (addr == KEY_A2);
    assign sect_oh = NSECT'(1) << addr[ADDR_W-1 -: SECT_W];

    // Pause is honoured only while an erase is actually running.
    assign suspend_req = wr_en && ers_run && (wdata == K_PAUSE);
    assign erase_sel   = sel_nxt;

    // Next-state and request decode for one bus write.
    always_comb begin
        st_nxt     = st;
        sel_nxt    = sel;
        tmr_nxt    = tmr;
        go_prog    = 1'b0;
        go_erase   = 1'b0;
        resume_req = 1'b0;
        case (st)
            D_READ: if (wr_ok) begin
                if (wdata == K_FIRST && at_a1)       st_nxt = D_U1;
                else if (susp && wdata == K_SECTOR)  resume_req = 1'b1;
            end
            D_U1: if (wr_ok) st_nxt = (wdata == K_SECOND && at_a2) ? D_U2 : D_READ;
            D_U2: if (wr_ok) begin
                st_nxt = D_READ;
                if (at_a1) begin
                    if (wdata == K_PROGRAM)             st_nxt = D_PRG;
                    else if (wdata == K_ERASE && !susp) st_nxt = D_E1;
                    else if (wdata == K_FAST && !susp)  st_nxt = D_BYP;
                end
            end
            D_PRG: if (wr_ok) begin
                st_nxt  = D_READ;
                go_prog = !(susp && |(ers_mask & sect_oh));
            end
            D_E1: if (wr_ok) st_nxt = (wdata == K_FIRST && at_a1) ? D_E2 : D_READ;
            D_E2: if (wr_ok) st_nxt = (wdata == K_SECOND && at_a2) ? D_E3 : D_READ;
            D_E3: if (wr_ok) begin
                st_nxt = D_READ;
                if (wdata == K_WHOLE && at_a1) begin
                    sel_nxt  = '1;
                    go_erase = 1'b1;
                end else if (wdata == K_SECTOR) begin
                    st_nxt  = D_SEL;
                    sel_nxt = sect_oh;
                    tmr_nxt = '0;
                end
            end
            D_SEL: begin
                if (wr_ok) begin
                    if (wdata == K_SECTOR) begin
                        sel_nxt = sel | sect_oh;
                        tmr_nxt = '0;
                    end else begin
                        st_nxt = D_READ;
                    end
                end else if (tmr == TW'(SEL_WINDOW - 1)) begin
                    go_erase = 1'b1;
                    st_nxt   = D_READ;
                end else begin
                    tmr_nxt = tmr + 1'b1;
                end
            end
            D_BYP: if (wr_ok) begin
                if (wdata == K_PROGRAM)      st_nxt = D_BPRG;
                else if (wdata == K_LEAVE1)  st_nxt = D_BEXIT;
            end
            D_BPRG: if (wr_ok) begin
                go_prog = 1'b1;
                st_nxt  = D_BYP;
            end
            D_BEXIT: if (wr_ok) st_nxt = (wdata == K_LEAVE2) ? D_READ : D_BYP;
            default: st_nxt = D_READ;
        endcase
    end

    // Sequence state, sector set and window timer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= D_READ;
            sel <= '0;
            tmr <= '0;
        end else begin
            st  <= st_nxt;
            sel <= sel_nxt;
            tmr <= tmr_nxt;
        end
    end

    // R8: while collecting sectors at least one sector is chosen.
    a_r8_sel_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (st == D_SEL) |-> (sel != '0));

    // R11: no request reaches the engine while it is busy.
    a_r11_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !(go_prog || go_erase || resume_req));

endmodule

// File: rtl/nor_op_engine.sv
// Operation engine. Latches a program or erase request, times it in clock
// cycles and emits one-cycle apply strobes to the array. Erase runs a
// preprogram phase then an erase phase, each OP_CYCLES long, and can be
// frozen and continued. Assumes OP_CYCLES >= 2.
module nor_op_engine
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SECT_W    = 2,
    parameter int OP_CYCLES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go_prog,
    input  logic [ADDR_W-1:0]       prog_addr,
    input  logic [DW-1:0]           prog_data,
    input  logic                    go_erase,
    input  logic [(1<<SECT_W)-1:0]  erase_sel,
    input  logic                    suspend_req,
    input  logic                    resume_req,
    output logic                    busy,
    output logic                    prg_on,
    output logic                    ers_run,
    output logic                    susp,
    output logic [(1<<SECT_W)-1:0]  ers_mask,
    output logic [ADDR_W-1:0]       lat_addr,
    output logic [DW-1:0]           lat_data,
    output logic                    do_prog,
    output logic                    do_pre,
    output logic                    do_ers
);

    localparam int PW = $clog2(OP_CYCLES);
    localparam int EW = $clog2(2 * OP_CYCLES);

    logic           ers_on;
    logic [PW-1:0]  prg_cnt;
    logic [EW-1:0]  ers_cnt;

    assign ers_run = ers_on && !susp;
    assign busy    = prg_on || ers_run;
    assign do_prog = prg_on && (prg_cnt == PW'(OP_CYCLES - 1));
    assign do_pre  = ers_run && !suspend_req && (ers_cnt == EW'(OP_CYCLES - 1));
    assign do_ers  = ers_run && !suspend_req && (ers_cnt == EW'(2 * OP_CYCLES - 1));

    // Program timer and latched target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg_on   <= 1'b0;
            prg_cnt  <= '0;
            lat_addr <= '0;
            lat_data <= '0;
        end else if (go_prog) begin
            prg_on   <= 1'b1;
            prg_cnt  <= '0;
            lat_addr <= prog_addr;
            lat_data <= prog_data;
        end else if (prg_on) begin
            if (do_prog) prg_on  <= 1'b0;
            else         prg_cnt <= prg_cnt + 1'b1;
        end
    end

    // Erase timer with pause and continue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ers_on   <= 1'b0;
            susp     <= 1'b0;
            ers_cnt  <= '0;
            ers_mask <= '0;
        end else if (go_erase) begin
            ers_on   <= 1'b1;
            susp     <= 1'b0;
            ers_cnt  <= '0;
            ers_mask <= erase_sel;
        end else if (ers_on) begin
            if (suspend_req)       susp    <= 1'b1;
            else if (resume_req)   susp    <= 1'b0;
            else if (do_ers)       ers_on  <= 1'b0;
            else if (!susp)        ers_cnt <= ers_cnt + 1'b1;
        end
    end

    // R1: reset always leaves the engine idle.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !(prg_on || ers_on));

    // R5: an accepted program request makes the engine busy on the next cycle.
    a_r5_prog_starts: assert property (@(posedge clk) disable iff (!rst_n)
        go_prog |=> prg_on);

    // R5: the program ends right after its final counted cycle.
    a_r5_prog_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (do_prog && !go_prog) |=> !prg_on);

    // R10: a paused state only exists inside an erase.
    a_r10_susp_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
        susp |-> ers_on);

    // R11: a program never overlaps a running (unpaused) erase.
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(prg_on && ers_run));

    // R10: while paused the erase counter holds still.
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (susp && $past(susp) && !$past(go_erase)) |-> $stable(ers_cnt));

endmodule

// File: rtl/nor_array.sv
// Modelled array plus read path. Cells reset to the erased value, programs
// AND data into one cell, preprogram and erase act on whole sectors. Reads
// are registered; while busy they return a status byte whose bit 6 flips on
// every busy read.
module nor_array
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    do_prog,
    input  logic [ADDR_W-1:0]       lat_addr,
    input  logic [DW-1:0]           lat_data,
    input  logic                    do_pre,
    input  logic                    do_ers,
    input  logic [(1<<SECT_W)-1:0]  ers_mask,
    input  logic                    busy,
    input  logic                    prg_on,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DW-1:0]           rdata
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int SECT_SZ = DEPTH >> SECT_W;

    logic [DW-1:0] mem_q [DEPTH];
    logic          tog;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int SEC = g / SECT_SZ;
        // One cell: reset, AND-program, or sector-wide clear/set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '1;
            else if (do_prog && lat_addr == ADDR_W'(g))
                mem_q[g] <= mem_q[g] & lat_data;
            else if (do_pre && ers_mask[SEC])
                mem_q[g] <= '0;
            else if (do_ers && ers_mask[SEC])
                mem_q[g] <= '1;
        end
    end

    // Registered read port with status substitution while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            tog   <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rdata <= {prg_on ? ~lat_data[DW-1] : 1'b0, tog, {(DW-2){1'b0}}};
                tog   <= ~tog;
            end else begin
                rdata <= mem_q[rd_addr];
            end
        end
    end

    // R3: after a program the cell holds no 1 where the data had a 0.
    a_r3_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        do_prog |=> ((mem_q[$past(lat_addr)] & ~$past(lat_data)) == '0));

    // R8: a finished erase leaves the first cell of a chosen sector erased.
    a_r8_sector_set: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ers && ers_mask[0]) |=> (mem_q[0] == '1));

    // R6: consecutive busy reads flip the toggle bit.
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (tog != $past(tog)));

endmodule

// File: rtl/nor_cmd_ctrl.sv
// Top of the flash command sequence controller: decoder, operation engine
// and modelled array. ready is low only while an operation actually runs.
module nor_cmd_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SECT_W     = 2,
    parameter int OP_CYCLES  = 16,
    parameter int SEL_WINDOW = 8,
    parameter logic [ADDR_W-1:0] KEY_A1 = 8'h55,
    parameter logic [ADDR_W-1:0] KEY_A2 = 8'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              ready
);

    localparam int NSECT = 1 << SECT_W;

    logic              busy, prg_on, ers_run, susp;
    logic              go_prog, go_erase, suspend_req, resume_req;
    logic              do_prog, do_pre, do_ers;
    logic [NSECT-1:0]  erase_sel, ers_mask;
    logic [ADDR_W-1:0] lat_addr;
    logic [DW-1:0]     lat_data;

    assign ready = !busy;

    nor_cmd_decode #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .SEL_WINDOW(SEL_WINDOW),
        .KEY_A1(KEY_A1), .KEY_A2(KEY_A2)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .eng_busy(busy), .ers_run(ers_run), .susp(susp), .ers_mask(ers_mask),
        .go_prog(go_prog), .go_erase(go_erase), .erase_sel(erase_sel),
        .suspend_req(suspend_req), .resume_req(resume_req)
    );

    nor_op_engine #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .OP_CYCLES(OP_CYCLES)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .prog_addr(addr),
        .prog_data(wdata), .go_erase(go_erase), .erase_sel(erase_sel),
        .suspend_req(suspend_req), .resume_req(resume_req), .busy(busy),
        .prg_on(prg_on), .ers_run(ers_run), .susp(susp), .ers_mask(ers_mask),
        .lat_addr(lat_addr), .lat_data(lat_data), .do_prog(do_prog),
        .do_pre(do_pre), .do_ers(do_ers)
    );

    nor_array #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .do_prog(do_prog), .lat_addr(lat_addr),
        .lat_data(lat_data), .do_pre(do_pre), .do_ers(do_ers),
        .ers_mask(ers_mask), .busy(busy), .prg_on(prg_on), .rd_en(rd_en),
        .rd_addr(addr), .rdata(rdata)
    );

endmodule

// File: tb/tb_nor_cmd_ctrl.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor pops and
// compares them on the cycle the registered read data appears.
module tb_nor_cmd_ctrl;

    localparam int OP  = 16;
    localparam int WIN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ready;

    int checks = 0;
    int fails  = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    nor_cmd_ctrl #(.ADDR_W(8), .SECT_W(2), .OP_CYCLES(OP), .SEL_WINDOW(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each queued expectation with the registered read data.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rdata == e, t, rdata, e);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd_now(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic prog4(input logic [7:0] a, input logic [7:0] d);
        wr(8'h55, 8'hAA); wr(8'h2A, 8'h55); wr(8'h55, 8'hA0); wr(a, d);
    endtask

    task automatic erase_head();
        wr(8'h55, 8'hAA); wr(8'h2A, 8'h55); wr(8'h55, 8'h80);
        wr(8'h55, 8'hAA); wr(8'h2A, 8'h55);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (ready && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int n;
        logic [7:0] s1, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        rd_exp(8'h00, 8'hFF, "R1 cell 00 erased");
        rd_exp(8'hFF, 8'hFF, "R1 cell FF erased");

        // R5 busy length, R2 program
        prog4(8'h20, 8'h5C);
        chk(ready == 1'b0, "R5 busy after data write", ready, 0);
        wait_ready(n);
        chk(n == OP, "R5 program busy cycles", n, OP);
        rd_exp(8'h20, 8'h5C, "R2 programmed value");

        // R6 status during program
        prog4(8'h21, 8'h00);
        rd_now(8'h21, s1);
        rd_now(8'h21, s2);
        chk(s1[7] == 1'b1, "R6 status bit7 inverted", s1[7], 1);
        chk(s1[5:0] == 6'd0, "R6 status low bits", s1[5:0], 0);
        chk(s1[6] != s2[6], "R6 toggle bit changes", s2[6], !s1[6]);
        wait_ready(n);
        rd_exp(8'h21, 8'h00, "R2 second program");

        // R3 bits only clear
        prog4(8'h20, 8'hF3);
        wait_ready(n);
        rd_exp(8'h20, 8'h50, "R3 AND of old and new");

        // R4 bad address and bad data abort the sequence
        wr(8'h55, 8'hAA); wr(8'h2B, 8'h55); wr(8'h55, 8'hA0); wr(8'h20, 8'h00);
        chk(ready == 1'b1, "R4 bad address no op", ready, 1);
        wr(8'h55, 8'hAA); wr(8'h2A, 8'h54); wr(8'h55, 8'hA0); wr(8'h20, 8'h00);
        chk(ready == 1'b1, "R4 bad data no op", ready, 1);
        rd_exp(8'h20, 8'h50, "R4 cell unchanged");

        // R11 writes during busy are ignored
        prog4(8'h30, 8'h00);
        wr(8'h55, 8'hAA); wr(8'h2A, 8'h55); wr(8'h55, 8'hA0);
        wait_ready(n);
        wr(8'h40, 8'h00);
        chk(ready == 1'b1, "R11 no program from busy writes", ready, 1);
        rd_exp(8'h40, 8'hFF, "R11 cell untouched");
        rd_exp(8'h30, 8'h00, "R11 real program done");

        // R7 shortcut mode
        wr(8'h55, 8'hAA); wr(8'h2A, 8'h55); wr(8'h55, 8'h20);
        wr(8'h00, 8'hA0); wr(8'h50, 8'h0F);
        wait_ready(n);
        chk(n == OP, "R7 two-write program busy", n, OP);
        rd_exp(8'h50, 8'h0F, "R7 shortcut program value");
        wr(8'h13, 8'hA0); wr(8'h60, 8'h3C);
        wait_ready(n);
        rd_exp(8'h60, 8'h3C, "R7 second shortcut program");
        wr(8'h00, 8'h90); wr(8'h00, 8'h00);
        wr(8'h00, 8'hA0); wr(8'h61, 8'h00);
        chk(ready == 1'b1, "R7 no program after leaving", ready, 1);
        rd_exp(8'h61, 8'hFF, "R7 cell after leaving");

        // R9 chip erase
        erase_head(); wr(8'h55, 8'h10);
        chk(ready == 1'b0, "R9 busy at once", ready, 0);
        wait_ready(n);
        chk(n == 2 * OP, "R9 chip erase cycles", n, 2 * OP);
        rd_exp(8'h20, 8'hFF, "R9 cell 20 erased");
        rd_exp(8'h50, 8'hFF, "R9 cell 50 erased");
        rd_exp(8'h30, 8'hFF, "R9 cell 30 erased");

        // R6 status during erase
        erase_head(); wr(8'h55, 8'h10);
        rd_now(8'h00, s1);
        chk(s1[7] == 1'b0, "R6 erase status bit7", s1[7], 0);
        wait_ready(n);

        // R8 multi-sector erase
        prog4(8'h05, 8'h11); wait_ready(n);
        prog4(8'h45, 8'h22); wait_ready(n);
        prog4(8'h85, 8'h33); wait_ready(n);
        prog4(8'hC5, 8'h44); wait_ready(n);
        erase_head(); wr(8'h05, 8'h30); wr(8'h85, 8'h30);
        wait_busy(n);
        chk(n == WIN, "R8 window before erase", n, WIN);
        wait_ready(n);
        chk(n == 2 * OP, "R8 sector erase cycles", n, 2 * OP);
        rd_exp(8'h05, 8'hFF, "R8 sector 0 erased");
        rd_exp(8'h45, 8'h22, "R8 sector 1 kept");
        rd_exp(8'h85, 8'hFF, "R8 sector 2 erased");
        rd_exp(8'hC5, 8'h44, "R8 sector 3 kept");

        // R10 pause and continue
        prog4(8'h10, 8'h34); wait_ready(n);
        prog4(8'hC0, 8'h12); wait_ready(n);
        erase_head(); wr(8'hC0, 8'h30);
        wait_busy(n);
        wr(8'h00, 8'hB0);
        chk(ready == 1'b1, "R10 ready when paused", ready, 1);
        rd_exp(8'h10, 8'h34, "R10 read outside erase");
        prog4(8'h11, 8'h5A);
        chk(ready == 1'b0, "R10 program while paused", ready, 0);
        wait_ready(n);
        chk(n == OP, "R10 paused program cycles", n, OP);
        rd_exp(8'h11, 8'h5A, "R10 paused program value");
        prog4(8'hC1, 8'h00);
        chk(ready == 1'b1, "R10 program into erase set dropped", ready, 1);
        wr(8'h00, 8'h30);
        chk(ready == 1'b0, "R10 continue makes busy", ready, 0);
        wait_ready(n);
        chk(n == 2 * OP - 1, "R10 remaining erase cycles", n, 2 * OP - 1);
        rd_exp(8'hC0, 8'hFF, "R10 erased cell C0");
        rd_exp(8'hC1, 8'hFF, "R10 erased cell C1");
        rd_exp(8'h10, 8'h34, "R10 outside cell kept");
        rd_exp(8'h11, 8'h5A, "R10 paused program kept");

        // R12 hardware reset during a program
        prog4(8'h70, 8'h00);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(ready == 1'b1, "R12 ready after reset", ready, 1);
        rd_exp(8'h70, 8'hFF, "R12 array data not status");
        rd_exp(8'h11, 8'hFF, "R1 cells erased by reset");
        prog4(8'h70, 8'h0A);
        wait_ready(n);
        rd_exp(8'h70, 8'h0A, "R12 commands accepted after reset");

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule